// File: doc/BRIEF.md
# Asynchronous SRAM Sequencer

This block sits between a synchronous request port and an external asynchronous static RAM organised as 32K words of 8 bits. A client issues one read or one write at a time with a valid/ready handshake. The block registers the address and write data, then drives the memory's chip-select, output-enable and write-strobe lines (all active low) through a fixed sequence of phases. Each phase lasts a whole number of clock cycles. Those counts are worked out when the block is elaborated, from the clock period and the memory's minimum timing figures, so the same code serves a fast or a slow memory grade.

The memory's data pins are modelled as a split bus: an output word, an input word and a drive-enable that the pad ring turns into a tri-state buffer. A read holds the memory in output mode long enough to cover both address access and output-enable access time. It then captures the byte on the last clock of that phase and releases output-enable. After that it waits out the memory's output float time before anything else can use the bus.

A write asserts chip-select and the write strobe together, with output-enable held high and the block's drivers on. It keeps the strobe low long enough to cover strobe width, data setup and address setup, and ends by raising the strobe and releasing the drivers on the same edge. A short recovery phase then brings the whole write cycle up to its minimum length. With no work to do, every strobe is high, so the memory stays deselected in standby.

Top module: `async_sram_ctl`

## Requirements
- R1: With no transaction in progress, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1, `mem_dq_oe` is 0 and `req_ready` is 1.
- R2: A request is taken on a rising clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the next cycle until the transaction's last phase has ended. Request fields presented while `req_ready` is 0 have no effect on the memory pins or the memory contents.
- R3: A read (`req_write`=0) drives `mem_ce_n`=0, `mem_oe_n`=0, `mem_we_n`=1 for RD_CYC cycles, starting the cycle after acceptance. RD_CYC is the larger of ceil(T_AA_NS/period) and ceil(T_DOE_NS/period), which is 5 at the defaults (20 ns, 10 ns, 4 ns clock).
- R4: On the final clock edge of the read phase, `mem_dq_in` is stored into `rd_data`. `rd_valid` is 1 for exactly the one cycle after that edge, and `rd_data` holds the stored byte.
- R5: A write (`req_write`=1) drives `mem_ce_n`=0, `mem_we_n`=0, `mem_oe_n`=1 and `mem_dq_oe`=1 for WR_CYC cycles, starting the cycle after acceptance. WR_CYC is the largest of the strobe-width, data-setup and address-setup times in cycles, which is 4 at the defaults. `mem_we_n` rising and `mem_dq_oe` falling happen on the same edge.
- R6: After the write phase, all strobes stay high for REC_CYC = max(1, ceil(T_WC_NS/period) − WR_CYC) cycles before `req_ready` returns. That is 1 cycle at the defaults.
- R7: After the read phase, all strobes stay high and the drivers stay off for TURN_CYC = ceil(T_HZOE_NS/period) cycles (3 at the defaults) before `req_ready` returns.
- R8: While `mem_ce_n` is 0, `mem_addr` equals the accepted address and does not change. While `mem_dq_oe` is 1, `mem_dq_out` equals the accepted write data.
- R9: A cycle with `rst`=1 makes all strobes 1 and `mem_dq_oe` 0 from the next cycle, and returns the block to idle (`req_ready`=1).
- R10: `mem_dq_oe` is 1 only while `mem_oe_n` is 1 and has been 1 for at least TURN_CYC cycles, so the controller and the memory never drive the bus together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 15 | Word address |
| req_wdata | input | 8 | Write data |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` holds new read data |
| rd_data | output | 8 | Captured read data |
| mem_addr | output | 15 | Address to memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_in | input | 8 | Data returned from memory pins |
| mem_dq_oe | output | 1 | Enable for the data pad drivers |

## Verification
The bench's memory model returns the inverted byte until output-enable has been low for the full access window. A design that samples one clock early therefore captures the wrong data. The model also rejects a write strobe shorter than the required width, and it flags any cycle where the controller drives while output-enable is low or has only just risen. That catches a missing turnaround after a read that is followed at once by a write. Requests are issued back to back with valid held high, which exposes a controller that takes a second request while busy, or that changes the address in the middle of a phase. A reset is asserted in the middle of a write to show that the strobes and drivers are released at once.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_RTURN,
        ST_WRITE,
        ST_WREC
    } seq_state_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic drive;
    } pin_ctl_t;

    localparam pin_ctl_t CTL_STANDBY = '{ce_n: 1'b1, oe_n: 1'b1, we_n: 1'b1, drive: 1'b0};
    localparam pin_ctl_t CTL_READ    = '{ce_n: 1'b0, oe_n: 1'b0, we_n: 1'b1, drive: 1'b0};
    localparam pin_ctl_t CTL_WRITE   = '{ce_n: 1'b0, oe_n: 1'b1, we_n: 1'b0, drive: 1'b1};

    // Whole cycles needed to cover a time in ns at a clock period in ps, at least one.
    function automatic int unsigned ns_to_cycles(input int unsigned ns, input int unsigned period_ps);
        int unsigned c;
        c = (ns * 1000 + period_ps - 1) / period_ps;
        return (c == 0) ? 1 : c;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic pin_ctl_t ctl_for(input seq_state_e s);
        case (s)
            ST_READ:  return CTL_READ;
            ST_WRITE: return CTL_WRITE;
            default:  return CTL_STANDBY;
        endcase
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign done = (cnt_q == '0);

endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
    import sram_ctl_pkg::*;
#(
    parameter int CNT_W    = 3,
    parameter int RD_CYC   = 5,
    parameter int TURN_CYC = 3,
    parameter int WR_CYC   = 4,
    parameter int REC_CYC  = 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic             phase_done,
    output logic             req_ready,
    output logic             accept,
    output logic             capture,
    output logic             tmr_load,
    output logic [CNT_W-1:0] tmr_val,
    output pin_ctl_t         ctl
);
    seq_state_e state_q, state_d;
    pin_ctl_t   ctl_q;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        accept   = 1'b0;
        capture  = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    accept   = 1'b1;
                    tmr_load = 1'b1;
                    if (req_write) begin
                        state_d = ST_WRITE;
                        tmr_val = CNT_W'(WR_CYC - 1);
                    end else begin
                        state_d = ST_READ;
                        tmr_val = CNT_W'(RD_CYC - 1);
                    end
                end
            end
            ST_READ: begin
                if (phase_done) begin
                    capture  = 1'b1;
                    state_d  = ST_RTURN;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(TURN_CYC - 1);
                end
            end
            ST_WRITE: begin
                if (phase_done) begin
                    state_d  = ST_WREC;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(REC_CYC - 1);
                end
            end
            ST_RTURN, ST_WREC: begin
                if (phase_done) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            ctl_q   <= CTL_STANDBY;
        end else begin
            state_q <= state_d;
            ctl_q   <= ctl_for(state_d);
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign ctl       = ctl_q;

    // R2: taking a request makes the controller busy on the next cycle
    p_accept_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R1: whenever ready is offered, the memory sits deselected with drivers off
    p_ready_standby_r1: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (ctl_q.ce_n && ctl_q.oe_n && ctl_q.we_n && !ctl_q.drive));

endmodule

// File: rtl/sram_datapath.sv
module sram_datapath #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              capture,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mem_addr   <= '0;
            mem_dq_out <= '0;
            rd_data    <= '0;
            rd_valid   <= 1'b0;
        end else begin
            if (accept) begin
                mem_addr   <= req_addr;
                mem_dq_out <= req_wdata;
            end
            if (capture) rd_data <= mem_dq_in;
            rd_valid <= capture;
        end
    end

    // R4: the read-data flag is a single-cycle pulse
    p_rdvalid_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        rd_valid |=> !rd_valid);

endmodule

// File: rtl/async_sram_ctl.sv
module async_sram_ctl
    import sram_ctl_pkg::*;
#(
    parameter int unsigned CLK_PS    = 4000,
    parameter int unsigned ADDR_W    = 15,
    parameter int unsigned DATA_W    = 8,
    parameter int unsigned T_AA_NS   = 20,
    parameter int unsigned T_DOE_NS  = 10,
    parameter int unsigned T_HZOE_NS = 10,
    parameter int unsigned T_PWE_NS  = 14,
    parameter int unsigned T_SD_NS   = 13,
    parameter int unsigned T_AW_NS   = 14,
    parameter int unsigned T_WC_NS   = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_ce_n,
    output logic              mem_oe_n,
    output logic              mem_we_n,
    output logic [DATA_W-1:0] mem_dq_out,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_dq_oe
);
    localparam int unsigned RD_CYC   = max2(ns_to_cycles(T_AA_NS, CLK_PS), ns_to_cycles(T_DOE_NS, CLK_PS));
    localparam int unsigned TURN_CYC = ns_to_cycles(T_HZOE_NS, CLK_PS);
    localparam int unsigned WR_CYC   = max2(ns_to_cycles(T_PWE_NS, CLK_PS),
                                            max2(ns_to_cycles(T_SD_NS, CLK_PS), ns_to_cycles(T_AW_NS, CLK_PS)));
    localparam int unsigned WC_CYC   = ns_to_cycles(T_WC_NS, CLK_PS);
    localparam int unsigned REC_CYC  = (WC_CYC > WR_CYC + 1) ? (WC_CYC - WR_CYC) : 1;
    localparam int unsigned MAX_CYC  = max2(max2(RD_CYC, TURN_CYC), max2(WR_CYC, REC_CYC));
    localparam int          CNT_W    = $clog2(MAX_CYC + 1);

    logic             accept, capture, tmr_load, phase_done;
    logic [CNT_W-1:0] tmr_val;
    pin_ctl_t         ctl;

    sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .done     (phase_done)
    );

    sram_seq_fsm #(
        .CNT_W    (CNT_W),
        .RD_CYC   (int'(RD_CYC)),
        .TURN_CYC (int'(TURN_CYC)),
        .WR_CYC   (int'(WR_CYC)),
        .REC_CYC  (int'(REC_CYC))
    ) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_write  (req_write),
        .phase_done (phase_done),
        .req_ready  (req_ready),
        .accept     (accept),
        .capture    (capture),
        .tmr_load   (tmr_load),
        .tmr_val    (tmr_val),
        .ctl        (ctl)
    );

    sram_datapath #(.ADDR_W(int'(ADDR_W)), .DATA_W(int'(DATA_W))) u_dp (
        .clk        (clk),
        .rst        (rst),
        .accept     (accept),
        .capture    (capture),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .mem_dq_in  (mem_dq_in),
        .mem_addr   (mem_addr),
        .mem_dq_out (mem_dq_out),
        .rd_data    (rd_data),
        .rd_valid   (rd_valid)
    );

    assign mem_ce_n  = ctl.ce_n;
    assign mem_oe_n  = ctl.oe_n;
    assign mem_we_n  = ctl.we_n;
    assign mem_dq_oe = ctl.drive;

    // R9: reset releases every strobe and the drivers on the following cycle
    p_reset_release_r9: assert property (@(posedge clk)
        rst |=> (mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe));

    // R8: address register does not move while the chip is selected
    p_addr_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !$past(mem_ce_n)) |-> $stable(mem_addr));

    // R8: driven write data is steady for the whole strobe
    p_wdata_stable_r8: assert property (@(posedge clk) disable iff (rst)
        (mem_dq_oe && $past(mem_dq_oe)) |-> $stable(mem_dq_out));

    // R10: drivers only turn on after output-enable was already high
    p_no_contention_r10: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (mem_oe_n && $past(mem_oe_n)));

endmodule

// File: tb/async_sram_ctl_test.sv
`timescale 1ns/1ps
module async_sram_ctl_test;

    localparam int RD   = 5;
    localparam int TURN = 3;
    localparam int WR   = 4;
    localparam int REC  = 1;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [14:0] req_addr  = '0;
    logic [7:0]  req_wdata = '0;
    logic        req_ready, rd_valid;
    logic [7:0]  rd_data;
    logic [14:0] mem_addr;
    logic        mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [7:0]  mem_dq_out;
    logic [7:0]  mem_dq_in = '0;

    always #2 clk = ~clk;

    async_sram_ctl uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data),
        .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
        .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit running = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h @%0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    // ---------------- reference model: expected per-cycle pin picture ----------------
    typedef struct {
        bit    ce_n, oe_n, we_n, drv, ready, rdv;
        int    addr, wdata, rdata;
        string tag;
    } exp_t;

    exp_t q[$];
    bit   exp_ready = 1'b1;
    int   ref_mem[int];
    int   sram[int];

    function automatic int ref_rd(input int a);
        return ref_mem.exists(a) ? ref_mem[a] : 0;
    endfunction

    function automatic int sram_rd(input int a);
        return sram.exists(a) ? sram[a] : 0;
    endfunction

    function automatic exp_t mk(input bit ce, oe, we, drv, rdv, input int a, wd, rd, input string t);
        exp_t e;
        e.ce_n = ce; e.oe_n = oe; e.we_n = we; e.drv = drv; e.ready = 1'b0; e.rdv = rdv;
        e.addr = a; e.wdata = wd; e.rdata = rd; e.tag = t;
        return e;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            q.delete();
        end else if (req_valid && exp_ready) begin
            int a;
            int d;
            a = int'(req_addr);
            d = int'(req_wdata);
            if (req_write) begin
                ref_mem[a] = d;
                for (int i = 0; i < WR; i++)  q.push_back(mk(0, 1, 0, 1, 0, a, d, 0, "R5 write phase"));
                for (int i = 0; i < REC; i++) q.push_back(mk(1, 1, 1, 0, 0, a, 0, 0, "R6 write recovery"));
            end else begin
                for (int i = 0; i < RD; i++)   q.push_back(mk(0, 0, 1, 0, 0, a, 0, 0, "R3 read phase"));
                for (int i = 0; i < TURN; i++) q.push_back(mk(1, 1, 1, 0, (i == 0), a, 0, ref_rd(a), "R7 read turnaround"));
            end
        end
    end

    always @(negedge clk) begin
        if (running) begin
            exp_t e;
            if (q.size() == 0) begin
                e = mk(1, 1, 1, 0, 0, 0, 0, 0, "R1 standby");
                e.ready = 1'b1;
                exp_ready = 1'b1;
            end else begin
                e = q.pop_front();
                exp_ready = 1'b0;
            end
            chk({mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready} ==
                {e.ce_n, e.oe_n, e.we_n, e.drv, e.ready}, {e.tag, " pins(ce,oe,we,drv,rdy) R2"},
                {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready},
                {e.ce_n, e.oe_n, e.we_n, e.drv, e.ready});
            if (!e.ce_n) chk(int'(mem_addr) == e.addr, "R8 address", mem_addr, e.addr);
            if (e.drv)   chk(int'(mem_dq_out) == e.wdata, "R8 write data", mem_dq_out, e.wdata);
            chk(rd_valid == e.rdv, "R4 rd_valid", rd_valid, e.rdv);
            if (e.rdv)   chk(int'(rd_data) == e.rdata, "R4 rd_data", rd_data, e.rdata);
        end
    end

    // ---------------- behavioural memory with timing checks ----------------
    int rd_age = 0, we_age = 0, oe_hi_age = 0;
    int last_addr = 0, last_dq = 0;

    always @(negedge clk) begin
        if (running) begin
            if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_age++;
            else rd_age = 0;
            mem_dq_in <= (rd_age >= RD) ? 8'(sram_rd(int'(mem_addr))) : ~8'(sram_rd(int'(mem_addr)));

            if (!mem_ce_n && !mem_we_n) begin
                we_age++;
                last_addr = int'(mem_addr);
                last_dq   = int'(mem_dq_out);
            end else if (we_age > 0) begin
                sram[last_addr] = last_dq;
                if (!rst) chk(we_age >= WR, "R5 strobe width", we_age, WR);
                we_age = 0;
            end

            if (mem_oe_n) oe_hi_age++;
            else oe_hi_age = 0;
            if (mem_dq_oe) chk(mem_oe_n && oe_hi_age >= TURN, "R10 bus contention",
                               oe_hi_age, TURN);
        end
    end

    // ---------------- stimulus ----------------
    task automatic issue(input bit w, input int a, input int d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = w;
        req_addr  = 15'(a);
        req_wdata = 8'(d);
        forever begin
            if (req_ready) begin
                @(posedge clk);
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic rest(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL R2 watchdog: actual=hung expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        running = 1'b1;
        // R9 / R1: reset state
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready, "R9 reset state",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11101);
        rest(4);

        // single writes and reads at the address extremes
        issue(1, 15'h0000, 8'hA5);
        issue(1, 15'h7FFF, 8'h3C);
        rest(2);
        issue(0, 15'h0000, 0);
        issue(0, 15'h7FFF, 0);
        rest(3);

        // back-to-back mixed traffic with valid held (R2: fields while busy ignored)
        issue(1, 15'h1234, 8'h00);
        issue(0, 15'h1234, 8'hFF);
        issue(1, 15'h2AAA, 8'hFF);
        issue(1, 15'h5555, 8'h81);
        issue(0, 15'h2AAA, 8'h77);
        issue(0, 15'h5555, 8'h66);
        issue(1, 15'h2AAA, 8'h42);
        issue(0, 15'h2AAA, 8'h00);
        issue(0, 15'h0001, 8'h00);
        rest(6);

        // reset in the middle of a write (R9)
        issue(1, 15'h0100, 8'h5A);
        @(negedge clk);
        req_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        chk(mem_ce_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready, "R9 reset mid-write",
            {mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}, 5'b11101);
        @(negedge clk);
        rst = 1'b0;
        rest(3);

        issue(0, 15'h0100, 0);
        issue(0, 15'h7FFF, 0);
        rest(12);
        chk(req_ready && mem_ce_n && !mem_dq_oe, "R1 final standby",
            {req_ready, mem_ce_n, mem_dq_oe}, 3'b110);
        finish_run();
    end

endmodule